// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial-clock timing of a synchronous serial master from its module clock. A control word chooses one of two divide laws. The linear law divides by an even ratio 2 × (N + 1), where N is an 8-bit field. The power-of-two law divides by 2^M, where M is a 4-bit exponent field. The block emits a one-cycle toggle strobe once every half period. It also emits the divided clock level and one strobe for each direction of edge, so the shift engine can launch and capture data without its own counter.

The engine tells the block whether an exchange is in progress. A new control word is taken only while no exchange is running, so a transfer never sees its clock rate change partway through. While the engine is disabled, the half-period counter and the clock level are held at zero. All outputs are registered and the reset is synchronous and active high.

Top module: `spi_clkdiv`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `tick`, `edge_rise` and `edge_fall` are 0 and `sclk_lvl` is 0. The held setting after reset gives a half period of one module clock.
- R2: With bit 12 of `cfg_word` set (linear law), the half period is N + 1 module clocks, where N is `cfg_word[7:0]`. Bits 11:8 have no effect in this law.
- R3: With bit 12 clear (power-of-two law) and M = `cfg_word[11:8]` from 1 to 15, the half period is 2^(M-1) module clocks. Bits 7:0 have no effect in this law.
- R4: In the power-of-two law, M = 0 gives a half period of one module clock, which is the same as a ratio of 2.
- R5: `tick` pulses for one cycle at the end of each half period, and `sclk_lvl` inverts on the same cycle, so high and low phases are equal. `edge_rise` pulses when the level becomes 1 and `edge_fall` pulses when it becomes 0.
- R6: `cfg_word` is sampled on every clock edge at which `busy` is low. Changes to `cfg_word` while `busy` is high have no effect on the half period.
- R7: While `en` is low, `tick`, `edge_rise`, `edge_fall` and `sclk_lvl` are 0 from the next cycle on. After `en` rises, the first `tick` comes after exactly one full half period.
- R8: Linear law with N = 0 gives the fastest rate: `tick` on every enabled cycle, so the serial clock runs at half the module clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Engine enable; when low, the divider is held cleared |
| busy | input | 1 | Exchange in progress; when high, the held setting is frozen |
| cfg_word | input | 13 | [7:0] linear field N, [11:8] exponent M, [12] law select (1 = linear) |
| tick | output | 1 | One-cycle strobe at each half-period boundary |
| sclk_lvl | output | 1 | Divided clock level, 50% duty |
| edge_rise | output | 1 | Strobe when the level has just become 1 |
| edge_fall | output | 1 | Strobe when the level has just become 0 |

## Verification
The assertions check three things on every cycle. Each strobe comes with an inversion of the level. The held setting stays frozen while an exchange runs. A disabled engine drives quiet outputs, and the counter never runs past the held terminal count once that count has been stable for a cycle. The exact half-period length for each law, the M = 0 case, the fastest rate, the ignored field of the inactive law and the delay to the first strobe after enable can be shown only by the bench's scenarios. There, a behavioural model predicts every output on every cycle.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_clkdiv_decode.sv
module spi_clkdiv_decode #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 14
) (
  input  logic [LIN_W+EXP_W:0] cfg,
  output logic [CNT_W-1:0]     hp_m1
);
  import spi_clkdiv_pkg::*;

  localparam int EXP_LSB  = LIN_W;
  localparam int LAW_BIT  = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_m;
  div_law_e         law;
  logic [CNT_W-1:0] one_v;
  logic [CNT_W-1:0] pow_m1;

  assign lin_n = cfg[LIN_W-1:0];
  assign exp_m = cfg[EXP_LSB +: EXP_W];
  assign law   = div_law_e'(cfg[LAW_BIT]);
  assign one_v = {{(CNT_W-1){1'b0}}, 1'b1};

  // Exponent zero cannot be produced by toggling; it folds onto ratio 2.
  always_comb begin
    if (exp_m == '0) pow_m1 = '0;
    else             pow_m1 = (one_v << (exp_m - 1'b1)) - one_v;
  end

  always_comb begin
    if (law == LAW_LINEAR) hp_m1 = CNT_W'(lin_n);
    else                   hp_m1 = pow_m1;
  end
endmodule

// File: rtl/spi_clkdiv_hold.sv
module spi_clkdiv_hold #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [CNT_W-1:0] hp_m1_in,
  output logic [CNT_W-1:0] hp_m1_q
);
  always_ff @(posedge clk) begin
    if (rst)        hp_m1_q <= '0;
    else if (!busy) hp_m1_q <= hp_m1_in;
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hp_m1_q)); // R6
endmodule

// File: rtl/spi_clkdiv_phase.sv
module spi_clkdiv_phase #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] hp_m1,
  output logic             tick,
  output logic             sclk_q,
  output logic             rise,
  output logic             fall
);
  logic [CNT_W-1:0] cnt;
  logic             at_end;

  // Greater-or-equal keeps the counter safe when a smaller setting lands.
  assign at_end = (cnt >= hp_m1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      tick   <= 1'b0;
      sclk_q <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end else if (at_end) begin
      cnt    <= '0;
      tick   <= 1'b1;
      sclk_q <= ~sclk_q;
      rise   <= ~sclk_q;
      fall   <= sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
      tick   <= 1'b0;
      rise   <= 1'b0;
      fall   <= 1'b0;
    end
  end

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    tick |-> (sclk_q != $past(sclk_q))); // R5
  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |-> (tick && (rise == sclk_q))); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    $stable(hp_m1) |-> (cnt <= hp_m1)); // R5
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!tick && !sclk_q && !rise && !fall)); // R7
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 busy,
  input  logic [LIN_W+EXP_W:0] cfg_word,
  output logic                 tick,
  output logic                 sclk_lvl,
  output logic                 edge_rise,
  output logic                 edge_fall
);
  import spi_clkdiv_pkg::*;

  localparam int CNT_W = int'(max_u(LIN_W, (1 << EXP_W) - 2));

  logic [CNT_W-1:0] hp_m1_next;
  logic [CNT_W-1:0] hp_m1_held;

  spi_clkdiv_decode #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_decode (
    .cfg   (cfg_word),
    .hp_m1 (hp_m1_next)
  );

  spi_clkdiv_hold #(.CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .hp_m1_in (hp_m1_next),
    .hp_m1_q  (hp_m1_held)
  );

  spi_clkdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .hp_m1  (hp_m1_held),
    .tick   (tick),
    .sclk_q (sclk_lvl),
    .rise   (edge_rise),
    .fall   (edge_fall)
  );
endmodule

// File: tb/spi_clkdiv_bench.sv
`timescale 1ns/1ps
module spi_clkdiv_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        busy = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        tick, sclk_lvl, edge_rise, edge_fall;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference
  int m_cnt = 0;
  int m_half = 1;
  bit m_tick = 0, m_lvl = 0, m_rise = 0, m_fall = 0;
  int first_tick_gap = -1;
  int since_en = 0;

  always #4 clk = ~clk;

  spi_clkdiv u_spi_clkdiv (
    .clk(clk), .rst(rst), .en(en), .busy(busy), .cfg_word(cfg_word),
    .tick(tick), .sclk_lvl(sclk_lvl), .edge_rise(edge_rise), .edge_fall(edge_fall)
  );

  function automatic int half_of(input logic [12:0] w);
    if (w[12]) return int'(w[7:0]) + 1;
    if (w[11:8] == 4'd0) return 1;
    return 1 << (int'(w[11:8]) - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_half = 1; m_tick = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
    end else begin
      if (!en) begin
        m_cnt = 0; m_tick = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
      end else if (m_cnt + 1 >= m_half) begin
        m_cnt = 0; m_tick = 1; m_lvl = !m_lvl; m_rise = m_lvl; m_fall = !m_lvl;
      end else begin
        m_cnt = m_cnt + 1; m_tick = 0; m_rise = 0; m_fall = 0;
      end
      if (!busy) m_half = half_of(cfg_word);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if ({tick, sclk_lvl, edge_rise, edge_fall} !== {m_tick, m_lvl, m_rise, m_fall}) begin
        n_bad++;
        $display("FAIL %s t=%0t tick/lvl/rise/fall actual=%b%b%b%b expected=%b%b%b%b",
                 tag, $time, tick, sclk_lvl, edge_rise, edge_fall,
                 m_tick, m_lvl, m_rise, m_fall);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // explicit check: first tick after enable arrives after one half period (R7)
  task automatic first_tick_check(input int expect_gap);
    int gap;
    gap = 0;
    @(negedge clk);
    en = 1'b1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      gap++;
      if (tick === 1'b1) break;
    end
    n_vec++;
    if (gap != expect_gap) begin
      n_bad++;
      $display("FAIL R7 first tick gap actual=%0d expected=%0d", gap, expect_gap);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    cycles(3);
    rst = 1'b0;
    cycles(3);

    // R2: linear law, exponent field filled with junk
    tag = "R2";
    cfg_word = {1'b1, 4'hA, 8'd3};
    en = 1'b1;
    cycles(60);
    cfg_word = {1'b1, 4'h0, 8'd6};
    cycles(60);

    // R8: fastest rate
    tag = "R8";
    cfg_word = {1'b1, 4'h7, 8'd0};
    cycles(20);

    // R3: power-of-two law, linear field filled with junk
    tag = "R3";
    cfg_word = {1'b0, 4'd3, 8'hFF};
    cycles(50);
    cfg_word = {1'b0, 4'd5, 8'h5A};
    cycles(100);
    cfg_word = {1'b0, 4'd1, 8'h00};
    cycles(20);

    // R4: exponent zero behaves as ratio 2
    tag = "R4";
    cfg_word = {1'b0, 4'd0, 8'h33};
    cycles(20);

    // R6: changes while busy are ignored
    tag = "R6";
    cfg_word = {1'b1, 4'd0, 8'd2};
    cycles(10);
    busy = 1'b1;
    cfg_word = {1'b1, 4'd0, 8'd9};
    cycles(40);
    cfg_word = {1'b0, 4'd0, 8'd0};
    cycles(20);
    busy = 1'b0;
    cfg_word = {1'b1, 4'd0, 8'd4};
    cycles(40);

    // R7: disable holds outputs quiet, first tick after one half period
    tag = "R7";
    en = 1'b0;
    cycles(10);
    cfg_word = {1'b1, 4'd0, 8'd4};
    first_tick_check(5);
    cycles(30);
    en = 1'b0;
    cfg_word = {1'b0, 4'd4, 8'd0};
    cycles(5);
    first_tick_check(8);
    cycles(40);

    // R5: long run at a large half period, duty and edge strobes
    tag = "R5";
    cfg_word = {1'b0, 4'd9, 8'd0};
    cycles(1200);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule